// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers the two interrupt causes of a graphics engine and presents them to a host through a small register port. The first cause is a single-cycle completion pulse, sent when a frame has been rendered. The block latches that pulse. The second cause is an out-of-memory level that the source holds until new memory is supplied, and the block reports it live. A single registered interrupt line goes to the host. It is the OR over every source that is both pending and enabled.

The host acknowledges a completion by writing a 1 to its status bit, and that bit then stays clear until the next pulse. The out-of-memory bit has no storage, so it cannot be acknowledged away. While its level is high it reads back as set. To silence it, the host masks it through the disable alias and unmasks it later through the enable alias. Both aliases read back the same mask.

Three word addresses are decoded: 0 selects status, 1 selects enable-set and 2 selects enable-clear. In every register, bit 0 belongs to the completion source and bit 2 belongs to the out-of-memory source. Every other bit reads as zero.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable mask is 0, the latched completion bit is 0 and host_irq is 0. A status read then shows only the live out-of-memory level, at bit 2.
- R2: A status read (address 0) returns the latched completion bit at bit 0 and the live out-of-memory level at bit 2. All other bits read 0.
- R3: A completion pulse sets status bit 0 at the next clock edge. The bit stays set until a write-1-to-clear.
- R4: Writing to status clears bit 0 when wdata bit 0 is 1. When wdata bit 0 is 0, the bit is left unchanged.
- R5: Status bit 2 follows oom_level. A write of 1 to it has no effect while the level is high.
- R6: If a completion pulse and a write-1-to-clear of bit 0 fall in the same cycle, bit 0 ends the cycle set.
- R7: Writing to enable-set (address 1) sets each mask bit whose wdata bit is 1. A wdata bit of 0 leaves the mask bit unchanged.
- R8: Writing to enable-clear (address 2) clears each mask bit whose wdata bit is 1. A wdata bit of 0 leaves the mask bit unchanged.
- R9: A read of address 1 or address 2 returns the mask, with the completion enable at bit 0 and the out-of-memory enable at bit 2. All other bits read 0, including bits that were written as 1.
- R10: host_irq is registered. Its value after an edge equals the OR of (status AND mask) as those stood before that edge.
- R11: rdata presents, after each edge, the register selected by the address sampled at that edge. An unmapped address reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the address |
| frame_done_pulse | input | 1 | Single-cycle completion event |
| oom_level | input | 1 | Out-of-memory condition, held by the source |
| host_irq | output | 1 | Registered interrupt request to the host |

## Verification
Two cases are hard to reach from the ports. In the first, a fresh completion pulse lands in the very cycle of a write-1-to-clear. The bench drives the pulse and the status write on the same falling edge so that one rising edge sees both. In the second, the out-of-memory bit must survive its own acknowledge. The bench holds the level high, writes a clear and reads the bit back. Around these cases the bench sweeps every combination of mask, latched completion and live level. For each combination it computes the expected status, mask and host_irq values arithmetically.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W   = 32;
    localparam int FD_BIT   = 0;
    localparam int OOM_BIT  = 2;
    localparam int STAT_OFS = 0;
    localparam int ESET_OFS = 1;
    localparam int ECLR_OFS = 2;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_ESET = 2'd1,
        SEL_ECLR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oom;
        logic fd;
    } src_t;

    function automatic src_t word_to_src(input logic [DATA_W-1:0] w);
        src_t s;
        s.fd  = w[FD_BIT];
        s.oom = w[OOM_BIT];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] src_to_word(input src_t s);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[FD_BIT]  = s.fd;
        w[OOM_BIT] = s.oom;
        return w;
    endfunction

    function automatic logic any_pending(input src_t stat, input src_t mask);
        return |(stat & mask);
    endfunction

endpackage

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fd_pulse,
    input  logic oom_lvl,
    input  logic ack_we,
    input  src_t ack_bits,
    output src_t stat
);
    logic fd_q;

    always_ff @(posedge clk) begin
        if (rst)
            fd_q <= 1'b0;
        else if (fd_pulse)
            fd_q <= 1'b1;
        else if (ack_we && ack_bits.fd)
            fd_q <= 1'b0;
    end

    always_comb begin
        stat.fd  = fd_q;
        stat.oom = oom_lvl;
    end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_we,
    input  logic clr_we,
    input  src_t bits,
    output src_t mask
);
    src_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (set_we)
            mask_q <= mask_q | bits;
        else if (clr_we)
            mask_q <= mask_q & ~bits;
    end

    assign mask = mask_q;
endmodule

// File: rtl/irqc_out.sv
module irqc_out
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  src_t              stat,
    input  src_t              mask,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            unique case (sel)
                SEL_STAT:           rdata_q <= src_to_word(stat);
                SEL_ESET, SEL_ECLR: rdata_q <= src_to_word(mask);
                default:            rdata_q <= '0;
            endcase
            irq_q <= any_pending(stat, mask);
        end
    end

    assign rdata = rdata_q;
    assign irq   = irq_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_done_pulse,
    input  logic              oom_level,
    output logic              host_irq
);
    reg_sel_e sel;
    src_t     wbits;
    src_t     stat_w;
    src_t     mask_w;

    always_comb begin
        if (bus_addr == ADDR_W'(STAT_OFS))
            sel = SEL_STAT;
        else if (bus_addr == ADDR_W'(ESET_OFS))
            sel = SEL_ESET;
        else if (bus_addr == ADDR_W'(ECLR_OFS))
            sel = SEL_ECLR;
        else
            sel = SEL_NONE;
    end

    assign wbits = word_to_src(bus_wdata);

    irqc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .fd_pulse (frame_done_pulse),
        .oom_lvl  (oom_level),
        .ack_we   (bus_wr && sel == SEL_STAT),
        .ack_bits (wbits),
        .stat     (stat_w)
    );

    irqc_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_we (bus_wr && sel == SEL_ESET),
        .clr_we (bus_wr && sel == SEL_ECLR),
        .bits   (wbits),
        .mask   (mask_w)
    );

    irqc_out u_out (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .stat  (stat_w),
        .mask  (mask_w),
        .rdata (bus_rdata),
        .irq   (host_irq)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              frame_done_pulse,
    input logic              oom_level,
    input logic              host_irq,
    input src_t              stat,
    input src_t              mask
);
    logic stat_wr, eset_wr, eclr_wr;
    assign stat_wr = bus_wr && bus_addr == ADDR_W'(STAT_OFS);
    assign eset_wr = bus_wr && bus_addr == ADDR_W'(ESET_OFS);
    assign eclr_wr = bus_wr && bus_addr == ADDR_W'(ECLR_OFS);

    p_pulse_latches_r3: assert property (@(posedge clk) disable iff (rst)
        frame_done_pulse |=> stat.fd);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && bus_wdata[FD_BIT] && !frame_done_pulse) |=> !stat.fd);

    p_fd_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!frame_done_pulse && !(stat_wr && bus_wdata[FD_BIT])) |=> $stable(stat.fd));

    p_collision_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && frame_done_pulse) |=> stat.fd);

    p_set_alias_r7: assert property (@(posedge clk) disable iff (rst)
        eset_wr |=> mask == ($past(mask) | word_to_src($past(bus_wdata))));

    p_clr_alias_r8: assert property (@(posedge clk) disable iff (rst)
        eclr_wr |=> mask == ($past(mask) & ~word_to_src($past(bus_wdata))));

    p_oom_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (oom_level && mask.oom) |=> host_irq);

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !host_irq);
endmodule

bind irqc_top irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_addr         (bus_addr),
    .bus_wr           (bus_wr),
    .bus_wdata        (bus_wdata),
    .frame_done_pulse (frame_done_pulse),
    .oom_level        (oom_level),
    .host_irq         (host_irq),
    .stat             (stat_w),
    .mask             (mask_w)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          frame_done_pulse = 1'b0;
    logic          oom_level = 1'b0;
    logic          host_irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic m_fd, en_fd, en_oom;

    always #4 clk = ~clk;

    irqc_top #(.ADDR_W(AW)) u_dut (
        .clk              (clk),
        .rst              (rst),
        .bus_addr         (bus_addr),
        .bus_wr           (bus_wr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .frame_done_pulse (frame_done_pulse),
        .oom_level        (oom_level),
        .host_irq         (host_irq)
    );

    function automatic logic [31:0] exp_stat();
        return {29'd0, oom_level, 1'b0, m_fd};
    endfunction

    function automatic logic [31:0] exp_mask();
        return {29'd0, en_oom, 1'b0, en_fd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 0 && d[0]) m_fd = 1'b0;
        if (a == 1) begin en_fd = en_fd | d[0]; en_oom = en_oom | d[2]; end
        if (a == 2) begin en_fd = en_fd & ~d[0]; en_oom = en_oom & ~d[2]; end
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse();
        @(negedge clk);
        frame_done_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_done_pulse = 1'b0;
        m_fd = 1'b1;
    endtask

    task automatic chk_irq(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, {31'd0, host_irq}, {31'd0, (m_fd & en_fd) | (oom_level & en_oom)});
    endtask

    initial begin
        m_fd = 0; en_fd = 0; en_oom = 0;
        oom_level = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'd0, host_irq}, 32'd0);
        rd(1, 32'd0, "R1 mask after reset");
        rd(0, 32'h4, "R1 status shows live level only");
        oom_level = 1'b0;

        // R2 R3 R7 R9 R10: sweep mask x latched event x live level
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int o = 0; o < 2; o++) begin
                    wr(2, 32'h5);
                    wr(0, 32'h1);
                    oom_level = o[0];
                    if (f == 1) pulse();
                    wr(1, {29'd0, m[1], 1'b0, m[0]});
                    rd(0, exp_stat(), "R2 R3 status sweep");
                    rd(1, exp_mask(), "R9 mask via set alias");
                    rd(2, exp_mask(), "R9 mask via clear alias");
                    chk_irq("R10 irq sweep");
                end
            end
        end

        // R4: write 0 leaves latched bit, write 1 clears
        oom_level = 1'b0;
        pulse();
        wr(0, 32'hFFFF_FFFE);
        rd(0, 32'h1, "R4 zero write keeps bit");
        wr(0, 32'h1);
        rd(0, 32'h0, "R4 one write clears bit");
        rd(0, 32'h0, "R3 stays clear without pulse");

        // R5: level survives acknowledge
        oom_level = 1'b1;
        wr(0, 32'h4);
        rd(0, 32'h4, "R5 level persists after clear");
        oom_level = 1'b0;
        rd(0, 32'h0, "R5 level drop follows input");

        // R6: pulse and clear in the same cycle
        @(negedge clk);
        bus_addr = AW'(0); bus_wr = 1'b1; bus_wdata = 32'h1; frame_done_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; frame_done_pulse = 1'b0; m_fd = 1'b1;
        rd(0, 32'h1, "R6 new event wins");

        // R7 R8 R9: zero bits ignored, unused bits read zero
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFA);
        rd(1, 32'h0, "R7 zero bits ignored on set");
        wr(1, 32'hFFFF_FFFF);
        rd(2, 32'h5, "R9 unused bits read zero");
        wr(2, 32'h0000_0004);
        rd(1, 32'h1, "R8 one bit disables");
        wr(2, 32'hFFFF_FFFA);
        rd(1, 32'h1, "R8 zero bits ignored on clear");
        chk_irq("R10 enabled pending event");

        // R11: unmapped address
        wr(3, 32'hFFFF_FFFF);
        wr(9, 32'hFFFF_FFFF);
        rd(3, 32'h0, "R11 unmapped reads zero");
        rd(1, 32'h1, "R11 unmapped write leaves mask");
        rd(0, 32'h1, "R11 unmapped write leaves status");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule